// File: doc/BRIEF.md
# Command-Word SPI Register Access Slave

This block is the serial front end of a register file. An external SPI master lowers chip select and shifts in a 16-bit command word. The command word holds a fixed enable code, a direction flag and a 10-bit starting register address. If the enable code matches, the block streams register words in either direction. For reads, it puts consecutive register values on a three-state data output. For writes, it turns each received 16-bit word into one write strobe on a parallel register-file port. After every word the register address moves to the next location, so one frame can cover a whole run of registers.

The serial pins are brought into the system clock domain through two-flop synchronizers and edge detection. The system clock must therefore run at least eight times faster than SCLK. The register file's read data is taken combinationally for the address shown on the port. Raising chip select at any moment returns the block to waiting for a new command.

Top module: `spireg_slave`

## Requirements
- R1: After chip select falls, the first 16 bits sampled on rising SCLK edges form the command word, MSB first. Bits [15:11] are the enable code, bit [10] is the direction (1 = read, 0 = write) and bits [9:0] are the starting register address.
- R2: If the enable code is not 5'b11100, the rest of the frame is ignored until chip select rises: no write strobe occurs and the DOUT enable stays low, whatever arrives on DIN.
- R3: In a read frame, each 16-bit register value is driven on DOUT MSB first. DOUT changes after falling SCLK edges so the master can sample it on rising edges, and the first bit is valid before the first rising edge after the command. DIN has no effect during this phase.
- R4: In a read frame, the register address advances by one after each 16-bit word, so consecutive registers stream out while chip select stays low.
- R5: In a write frame, each complete 16-bit word received after the command produces exactly one single-cycle write strobe. The strobe carries that word as write data and the current register address.
- R6: In a write frame, the register address advances by one after each write strobe.
- R7: The register address wraps from 10'h3FF to 10'h000 in both directions of transfer.
- R8: The DOUT enable is low while the command word is being received and whenever chip select is high.
- R9: Chip select going high discards any partial word, with no write strobe, and the next frame starts with a fresh command word. A final rising SCLK edge that reaches the block in the same cycle as chip select going high is discarded too.
- R10: During and right after reset, the DOUT enable and the write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master (idles low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_din | input | 1 | Serial data from the master |
| spi_dout | output | 1 | Serial data to the master |
| spi_dout_oe | output | 1 | Output enable of the DOUT three-state driver |
| rf_addr | output | 10 | Register-file address for reads and writes |
| rf_wdata | output | 16 | Register-file write data |
| rf_we | output | 1 | Single-cycle register-file write strobe |
| rf_rdata | input | 16 | Register-file read data for rf_addr |

## Verification
Two events can land in one cycle: the rising SCLK edge that completes a data word, and chip select going high. The bench provokes this by raising both pins in the same clock cycle, so both cross the synchronizers together. It then checks that no write strobe appears and that the log of writes is unchanged. In the control case, chip select rises half an SCLK period later and the word must be written. A second overlap is the address wrap during a stream: the write and read bursts that start at 10'h3FF and 10'h3FE must reach address 10'h000 within the same frame.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int ADDR_W = 10;
    localparam int WORD_W = 16;
    localparam int CODE_W = 5;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CODE_W-1:0] EN_CODE = 5'b11100;
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_HALT = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bitcnt;
        logic [WORD_W-1:0]   rx;
        logic [WORD_W-1:0]   tx;
        logic [ADDR_W-1:0]   addr;
        logic                oe;
        logic                we;
        logic [WORD_W-1:0]   wdata;
    } ctrl_st_t;

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/spireg_edge.sv
module spireg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;

endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              dout_o,
    output logic              oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              we_o
);

    ctrl_st_t st_d, st_q;
    logic [WORD_W-1:0] word_in;

    assign word_in = {st_q.rx[WORD_W-2:0], din_i};

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (st_q.we) st_d.addr = st_q.addr + ADDR_ONE;
        if (cs_hi_i) begin
            st_d.phase  = PH_CMD;
            st_d.bitcnt = '0;
            st_d.oe     = 1'b0;
        end else begin
            if (rise_i && st_q.phase != PH_HALT) begin
                st_d.rx     = word_in;
                st_d.bitcnt = st_q.bitcnt + CNT_ONE;
                if (st_q.bitcnt == LAST_BIT) begin
                    unique case (st_q.phase)
                        PH_CMD: begin
                            if (word_in[WORD_W-1 -: CODE_W] == EN_CODE) begin
                                st_d.phase = word_in[ADDR_W] ? PH_RD : PH_WR;
                                st_d.addr  = word_in[ADDR_W-1:0];
                            end else begin
                                st_d.phase = PH_HALT;
                            end
                        end
                        PH_WR: begin
                            st_d.we    = 1'b1;
                            st_d.wdata = word_in;
                        end
                        PH_RD:   st_d.addr = st_q.addr + ADDR_ONE;
                        default: st_d.phase = PH_HALT;
                    endcase
                end
            end
            if (fall_i && st_q.phase == PH_RD) begin
                st_d.oe = 1'b1;
                st_d.tx = (st_q.bitcnt == '0) ? rdata_i : (st_q.tx << 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_CMD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o  = st_q.tx[WORD_W-1];
    assign oe_o    = st_q.oe;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign we_o    = st_q.we;

    // R8
    oe_cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_i |=> !oe_o);

    // R8
    oe_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> st_q.phase == PH_RD);

    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HALT) |-> (!we_o && !oe_o));

    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);

    // R6
    wr_addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> addr_o == $past(addr_o) + ADDR_ONE);

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_din,
    output logic              spi_dout,
    output logic              spi_dout_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [WORD_W-1:0] rf_rdata
);

    logic [2:0] pins_s;
    logic       sclk_rise;
    logic       sclk_fall;

    spireg_sync #(
        .W       (3),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sclk, spi_cs_n, spi_din}),
        .sync_o  (pins_s)
    );

    spireg_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (pins_s[2]),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    spireg_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi_i (pins_s[1]),
        .rise_i  (sclk_rise),
        .fall_i  (sclk_fall),
        .din_i   (pins_s[0]),
        .rdata_i (rf_rdata),
        .dout_o  (spi_dout),
        .oe_o    (spi_dout_oe),
        .addr_o  (rf_addr),
        .wdata_o (rf_wdata),
        .we_o    (rf_we)
    );

    // R10
    rst_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!rf_we && !spi_dout_oe));

endmodule

// File: tb/spireg_slave_tb_top.sv
module spireg_slave_tb_top;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout;
    logic        dout_oe;
    logic [9:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic        rf_we;
    logic [15:0] rf_rdata;

    int n_chk = 0;
    int n_err = 0;
    int log_n = 0;
    logic [9:0]  log_a [0:63];
    logic [15:0] log_d [0:63];

    always #2 clk = ~clk;

    function automatic logic [15:0] model(input logic [9:0] a);
        logic [31:0] p;
        p = {22'd0, a} * 32'd40503;
        return p[15:0] ^ 16'h1234;
    endfunction

    assign rf_rdata = model(rf_addr);

    spireg_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_din     (din),
        .spi_dout    (dout),
        .spi_dout_oe (dout_oe),
        .rf_addr     (rf_addr),
        .rf_wdata    (rf_wdata),
        .rf_we       (rf_we),
        .rf_rdata    (rf_rdata)
    );

    always @(posedge clk) begin
        if (rf_we && log_n < 64) begin
            log_a[log_n] <= rf_addr;
            log_d[log_n] <= rf_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one SCLK period: drive din, sample dout before the rising edge
    task automatic spi_bit(input logic b, output logic so, output logic soe);
        din = b;
        wait_clk(HALF);
        so  = dout;
        soe = dout_oe;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic send_cmd(input logic [4:0] code, input logic rw, input logic [9:0] a, output logic any_oe);
        logic [15:0] w;
        logic so, soe;
        w = {code, rw, a};
        any_oe = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            spi_bit(w[i], so, soe);
            any_oe |= soe;
        end
    endtask

    task automatic read_word(output logic [15:0] w, output logic all_oe);
        logic so, soe;
        all_oe = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            spi_bit(logic'(i % 3 == 0), so, soe);
            w[i] = so;
            all_oe &= soe;
        end
    endtask

    task automatic write_bits(input logic [15:0] w, input int nbits, output logic any_oe);
        logic so, soe;
        any_oe = 1'b0;
        for (int i = 15; i > 15 - nbits; i--) begin
            spi_bit(w[i], so, soe);
            any_oe |= soe;
        end
    endtask

    task automatic t_reset();
        check(dout_oe == 1'b0, "R10 oe after reset", 32'(dout_oe), 0);
        check(rf_we == 1'b0, "R10 we after reset", 32'(rf_we), 0);
    endtask

    task automatic t_read(input logic [9:0] a0, input int nw, input string req);
        logic cmd_oe, all_oe;
        logic [15:0] w;
        logic [9:0] a;
        frame_begin();
        send_cmd(5'b11100, 1'b1, a0, cmd_oe);
        check(!cmd_oe, "R8 oe low during command", 32'(cmd_oe), 0);
        a = a0;
        for (int k = 0; k < nw; k++) begin
            read_word(w, all_oe);
            check(all_oe, "R3 oe high during read data", 32'(all_oe), 1);
            check(w == model(a), req, 32'(w), 32'(model(a)));
            a = a + 10'd1;
        end
        frame_end();
        check(!dout_oe, "R8 oe low with cs high", 32'(dout_oe), 0);
    endtask

    task automatic t_write(input logic [9:0] a0, input int nw, input string req);
        logic cmd_oe, oe;
        int base;
        logic [9:0] a;
        logic [15:0] d;
        base = log_n;
        frame_begin();
        send_cmd(5'b11100, 1'b0, a0, cmd_oe);
        check(!cmd_oe, "R1 oe low in write command", 32'(cmd_oe), 0);
        for (int k = 0; k < nw; k++) write_bits(16'hC3A5 ^ 16'(k * 16'h1111), 16, oe);
        frame_end();
        check(log_n == base + nw, "R5 one strobe per word", 32'(log_n - base), 32'(nw));
        a = a0;
        for (int k = 0; k < nw; k++) begin
            d = 16'hC3A5 ^ 16'(k * 16'h1111);
            check(log_a[base + k] == a, req, 32'(log_a[base + k]), 32'(a));
            check(log_d[base + k] == d, "R5 write data", 32'(log_d[base + k]), 32'(d));
            a = a + 10'd1;
        end
    endtask

    task automatic t_badcode();
        logic cmd_oe, oe, all_oe;
        logic [15:0] w;
        int base;
        base = log_n;
        frame_begin();
        send_cmd(5'b10100, 1'b0, 10'h010, cmd_oe);
        write_bits(16'hFFFF, 16, oe);
        write_bits(16'h1234, 16, oe);
        frame_end();
        check(log_n == base, "R2 bad code no write", 32'(log_n - base), 0);
        frame_begin();
        send_cmd(5'b11101, 1'b1, 10'h010, cmd_oe);
        read_word(w, all_oe);
        check(!dout_oe && !all_oe, "R2 bad code oe stays low", 32'(all_oe), 0);
        frame_end();
        t_read(10'h011, 1, "R1 fresh command after bad frame");
    endtask

    task automatic t_abort();
        logic cmd_oe, oe;
        int base;
        base = log_n;
        frame_begin();
        send_cmd(5'b11100, 1'b0, 10'h040, cmd_oe);
        write_bits(16'h0F0F, 16, oe);
        write_bits(16'hAAAA, 8, oe);
        frame_end();
        check(log_n == base + 1, "R9 partial word dropped", 32'(log_n - base), 1);
        t_read(10'h050, 2, "R9 new frame after abort");
    endtask

    task automatic t_collide();
        logic cmd_oe, oe, so, soe;
        int base;
        base = log_n;
        frame_begin();
        send_cmd(5'b11100, 1'b0, 10'h077, cmd_oe);
        write_bits(16'h5555, 15, oe);
        din = 1'b1;
        wait_clk(HALF);
        sclk = 1'b1;
        cs_n = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(4 * HALF);
        check(log_n == base, "R9 same-cycle cs rise drops word", 32'(log_n - base), 0);
        frame_begin();
        send_cmd(5'b11100, 1'b0, 10'h077, cmd_oe);
        write_bits(16'h5555, 15, oe);
        spi_bit(1'b1, so, soe);
        wait_clk(1);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
        check(log_n == base + 1, "R9 cs rise after last edge keeps word", 32'(log_n - base), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_read(10'h005, 3, "R4 read stream data");
        t_write(10'h120, 2, "R6 write address sequence");
        t_read(10'h3FE, 3, "R7 read wrap");
        t_write(10'h3FF, 2, "R7 write wrap");
        t_badcode();
        t_abort();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule